// File: doc/BRIEF.md
# SPI Register Port with Short and Long Address Spaces

This block is an SPI slave (mode 0) that lets an external host reach two register spaces through one serial link. The short space holds 64 byte-wide registers and is selected by a one-byte command. The long space holds 1024 byte locations and is selected by a two-byte command. In the long space, the transmit buffer starts at location 0x000 and covers 128 bytes. The receive buffer starts at 0x300 and covers 144 bytes.

The block oversamples SCK, MOSI and chip-select in the system clock domain and decodes each command. It then issues single-cycle read or write strobes on a parallel register-file port that the rest of the design serves. Within one chip-select frame the address advances after every data byte. This lets a host stream the transmit buffer in, or stream the receive buffer out starting from any location.

Top module: `spi_dual_regs`

## Requirements
- R1: A frame whose first byte has bit 7 = 0 is a short access: bits 6:1 of that byte are the register address and bit 0 selects write (1) or read (0); the access appears on the port with `reg_long` = 0 and `reg_addr[9:6]` = 0.
- R2: A frame whose first byte has bit 7 = 1 is a long access: over the first two bytes taken as a 16-bit word, bits 14:5 are the address, bit 4 is the write flag and bits 3:0 have no effect; the access appears with `reg_long` = 1.
- R3: Every complete data byte that follows a write command produces exactly one `reg_wr` pulse; the first goes to the commanded address and each later one to the next consecutive address.
- R4: A read command returns the addressed byte on MISO, MSB first, in the byte right after the command; further bytes clocked in the same frame return the following consecutive locations.
- R5: MOSI is sampled on rising SCK and MISO changes only after falling SCK (CPOL = 0, CPHA = 0).
- R6: Raising chip-select ends the frame at once: a partly shifted byte is dropped and produces no write, and the next frame starts again with a command byte.
- R7: MISO is 0 while chip-select is high and throughout write frames; it carries data only in the data phase of a read frame.
- R8: `reg_wr` and `reg_rd` are single-cycle pulses that are never high together; read data on `reg_rdata` is taken in the cycle after the `reg_rd` pulse.
- R9: A burst in the long space wraps from 0x3FF to 0x000; a burst in the short space stays in the short space and wraps from 0x3F to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_long | output | 1 | 1 = long space, 0 = short space |
| reg_addr | output | 10 | Location for the current strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
A write strobe is due about three system cycles after the rising SCK edge that completes a byte: two synchronizer stages plus one register stage. The bench checks the register file only after chip-select has been high for eight cycles, so every strobe has landed by then. A read strobe leaves at the same point, and its data is loaded two cycles later. The next MISO bit is set about three cycles after each falling SCK edge. The bench holds each SCK half period for seven system cycles and samples MISO in the same cycle in which it raises SCK. The freshly loaded bit is therefore always settled when it is sampled.

// File: rtl/spi_dual_regs.sv
module spi_dual_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       reg_wr,
  output logic       reg_rd,
  output logic       reg_long,
  output logic [9:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int LAW = 10;
  localparam int SAW = 6;
  localparam int DW  = 8;
  localparam int BCW = $clog2(DW);

  typedef enum logic [1:0] {PH_CMD, PH_LCMD, PH_DATA} phase_t;

  logic [2:0] sck_q;
  logic [1:0] mosi_q;
  logic [1:0] cs_q;
  phase_t         phase;
  logic [BCW-1:0] bit_cnt;
  logic [DW-2:0]  sh_in;
  logic [DW-1:0]  out_byte;
  logic [LAW-1:0] addr;
  logic           is_long, is_wr, rd_pend, miso_q;

  wire cs_idle  = cs_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire [DW-1:0] byte_in = {sh_in, mosi_q[1]};
  wire byte_done = !cs_idle && sck_rise && (bit_cnt == BCW'(DW-1));
  wire [LAW-1:0] addr_next = is_long ? addr + LAW'(1)
                                     : {{(LAW-SAW){1'b0}}, addr[SAW-1:0] + SAW'(1)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      mosi_q <= {mosi_q[0], spi_mosi};
      cs_q   <= {cs_q[0], spi_cs_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      sh_in     <= '0;
      out_byte  <= '0;
      addr      <= '0;
      is_long   <= 1'b0;
      is_wr     <= 1'b0;
      rd_pend   <= 1'b0;
      miso_q    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_long  <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      rd_pend <= reg_rd;
      if (rd_pend) out_byte <= reg_rdata;
      if (cs_idle) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh_in   <= byte_in[DW-2:0];
          bit_cnt <= bit_cnt + BCW'(1);
        end
        if (sck_fall && phase == PH_DATA && !is_wr)
          miso_q <= out_byte[BCW'(DW-1) - bit_cnt];
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              if (byte_in[DW-1]) begin
                addr  <= {byte_in[DW-2:0], 3'b000};
                phase <= PH_LCMD;
              end else begin
                addr     <= {{(LAW-SAW){1'b0}}, byte_in[SAW:1]};
                reg_addr <= {{(LAW-SAW){1'b0}}, byte_in[SAW:1]};
                reg_long <= 1'b0;
                is_long  <= 1'b0;
                is_wr    <= byte_in[0];
                reg_rd   <= !byte_in[0];
                phase    <= PH_DATA;
              end
            end
            PH_LCMD: begin
              addr     <= {addr[LAW-1:3], byte_in[7:5]};
              reg_addr <= {addr[LAW-1:3], byte_in[7:5]};
              reg_long <= 1'b1;
              is_long  <= 1'b1;
              is_wr    <= byte_in[4];
              reg_rd   <= !byte_in[4];
              phase    <= PH_DATA;
            end
            default: begin
              addr <= addr_next;
              if (is_wr) begin
                reg_wr    <= 1'b1;
                reg_wdata <= byte_in;
                reg_addr  <= addr;
              end else begin
                reg_rd   <= 1'b1;
                reg_addr <= addr_next;
              end
            end
          endcase
        end
      end
    end
  end

  assign spi_miso = miso_q;
endmodule

module spi_dual_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_idle,
  input logic       spi_miso,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       reg_long,
  input logic [9:0] reg_addr
);
  logic [9:0] last_wa;
  logic       last_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wa <= '0;
      last_v  <= 1'b0;
    end else if (cs_idle) begin
      last_v <= 1'b0;
    end else if (reg_wr) begin
      last_wa <= reg_addr;
      last_v  <= 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_wr && reg_rd)); // R8
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R8
  AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && !reg_long) |-> (reg_addr[9:6] == 4'd0)); // R1
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_idle |=> !spi_miso); // R7
  AST_MISO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |-> !spi_miso); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && last_v) |-> (reg_addr == (reg_long ? last_wa + 10'd1
                                                  : {4'd0, last_wa[5:0] + 6'd1}))); // R3
endmodule

bind spi_dual_regs spi_dual_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .spi_miso(spi_miso),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_long(reg_long), .reg_addr(reg_addr)
);

// File: tb/test_spi_dual_regs.sv
`timescale 1ns/1ps
module test_spi_dual_regs;
  localparam int HALF = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, reg_wr, reg_rd, reg_long;
  logic [9:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  spi_dual_regs i_spi_dual_regs (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_long(reg_long), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  logic [7:0] smem [64];
  logic [7:0] lmem [1024];
  logic [7:0] exp_s [64];
  logic [7:0] exp_l [1024];
  int wr_count = 0;
  int n_chk = 0, n_fail = 0;
  logic miso_in_wr = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) smem[i] <= 8'h00;
      for (int i = 0; i < 1024; i++) lmem[i] <= 8'h00;
      reg_rdata <= 8'h00;
    end else begin
      if (reg_wr) begin
        wr_count <= wr_count + 1;
        if (reg_long) lmem[reg_addr] <= reg_wdata;
        else smem[reg_addr[5:0]] <= reg_wdata;
      end
      if (reg_rd) reg_rdata <= reg_long ? lmem[reg_addr] : smem[reg_addr[5:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic shift(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      rx[i] = spi_miso;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic frame_start;
    @(negedge clk);
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_end;
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(spi_miso == 1'b0, "R7 miso idle", spi_miso, 0);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic short_write(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] r;
    frame_start();
    shift({1'b0, a, 1'b1}, 8, r);
    shift(d, 8, r);
    if (r != 0) miso_in_wr = 1'b1;
    frame_end();
    exp_s[a] = d;
  endtask

  task automatic short_read(input logic [5:0] a, output logic [7:0] d);
    logic [7:0] r;
    frame_start();
    shift({1'b0, a, 1'b0}, 8, r);
    shift(8'hA5, 8, d);
    frame_end();
  endtask

  task automatic long_write(input logic [9:0] a, input int n, input int k, input logic [3:0] pad);
    logic [7:0] r, d;
    frame_start();
    shift({1'b1, a[9:3]}, 8, r);
    shift({a[2:0], 1'b1, pad}, 8, r);
    for (int i = 0; i < n; i++) begin
      d = pat(i, k);
      shift(d, 8, r);
      if (r != 0) miso_in_wr = 1'b1;
      exp_l[10'(int'(a) + i)] = d;
    end
    frame_end();
  endtask

  task automatic long_read_chk(input logic [9:0] a, input int n, input logic [3:0] pad, input string req);
    logic [7:0] r;
    frame_start();
    shift({1'b1, a[9:3]}, 8, r);
    shift({a[2:0], 1'b0, pad}, 8, r);
    for (int i = 0; i < n; i++) begin
      shift(8'h00, 8, r);
      chk(r == exp_l[10'(int'(a) + i)], req, r, exp_l[10'(int'(a) + i)]);
    end
    frame_end();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, r;
    int base;
    for (int i = 0; i < 64; i++) exp_s[i] = 8'h00;
    for (int i = 0; i < 1024; i++) exp_l[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_miso == 1'b0 && reg_wr == 1'b0 && reg_rd == 1'b0, "R8 reset outputs",
        {spi_miso, reg_wr, reg_rd}, 0);

    // R1: short space sweep, write then read back every register
    for (int a = 0; a < 64; a++) short_write(6'(a), 8'((a * 7 + 3) ^ 8'h5A));
    for (int a = 0; a < 64; a++)
      chk(smem[a] == exp_s[a], "R1 short write landed", smem[a], exp_s[a]);
    for (int a = 0; a < 64; a++) begin
      short_read(6'(a), d);
      chk(d == exp_s[a], "R1 R4 short read", d, exp_s[a]);
    end

    // R2: long single access, pad nibble varies
    long_write(10'h215, 1, 3, 4'hF);
    chk(lmem[10'h215] == exp_l[10'h215], "R2 long write", lmem[10'h215], exp_l[10'h215]);
    long_read_chk(10'h215, 1, 4'h6, "R2 long read");

    // R3: transmit buffer burst
    base = wr_count;
    long_write(10'h000, 128, 1, 4'h0);
    chk(wr_count - base == 128, "R3 write pulse count", wr_count - base, 128);
    for (int a = 0; a < 128; a++)
      chk(lmem[a] == exp_l[a], "R3 burst address", lmem[a], exp_l[a]);
    chk(lmem[10'h080] == 8'h00, "R3 burst end", lmem[10'h080], 0);
    long_read_chk(10'h000, 128, 4'h3, "R4 tx burst read");

    // R4: receive buffer, streamed out from its second byte
    long_write(10'h300, 144, 2, 4'h9);
    long_read_chk(10'h301, 143, 4'h0, "R4 rx stream read");

    // R9: wrap in both spaces
    long_write(10'h3FE, 3, 4, 4'h0);
    chk(lmem[10'h3FF] == exp_l[10'h3FF] && lmem[0] == exp_l[0], "R9 long wrap",
        lmem[0], exp_l[0]);
    frame_start();
    shift(8'h7F, 8, r);
    shift(8'hC1, 8, r);
    shift(8'hC2, 8, r);
    frame_end();
    chk(smem[63] == 8'hC1, "R9 short burst first", smem[63], 8'hC1);
    chk(smem[0] == 8'hC2, "R9 short wrap", smem[0], 8'hC2);
    chk(lmem[0] == exp_l[0], "R9 short stays short", lmem[0], exp_l[0]);
    exp_s[63] = 8'hC1; exp_s[0] = 8'hC2;

    // R6: abort mid data byte and mid command
    base = wr_count;
    frame_start();
    shift(8'h80 | 8'(10'h123 >> 3), 8, r);
    shift({3'(10'h123), 1'b1, 4'h0}, 8, r);
    shift(8'h11, 8, r);
    shift(8'hEE, 5, r);
    frame_end();
    chk(wr_count - base == 1, "R6 partial byte dropped", wr_count - base, 1);
    chk(lmem[10'h124] == 8'h00, "R6 no write after abort", lmem[10'h124], 0);
    chk(lmem[10'h123] == 8'h11, "R6 complete byte kept", lmem[10'h123], 8'h11);
    exp_l[10'h123] = 8'h11;
    frame_start();
    shift(8'hFF, 3, r);
    frame_end();
    short_read(6'h05, d);
    chk(d == exp_s[5], "R6 fresh command after abort", d, exp_s[5]);

    // R5 R7: MISO silent in write frames, data valid at rising SCK
    chk(miso_in_wr == 1'b0, "R7 miso low in write frames", miso_in_wr, 0);
    long_read_chk(10'h122, 3, 4'hC, "R5 sampled on rising edge");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule